// File: doc/BRIEF.md
# Addressed Three-Wire Serial Frame Receiver

This block takes display and setup data from a host controller over three asynchronous wires: a chip enable, a serial clock and a serial data line. All three wires pass through synchronisers into a fast system clock, and only the rising edges of the serial clock are used to sample data. While chip enable is low, the block collects an 8-bit bus address. While chip enable is high, it collects a fixed-length data frame. A frame carries display bits, then setup or filler bits, and ends with a 2-bit group selector.

When chip enable falls, the block commits the frame only if three conditions hold: the address matched, the exact frame length was counted, and the group is legal for the current drive mode. A committed frame writes its display bits into one slice of a wide display latch. Frames for group 0 also load a 9-bit setup register. The setup register holds a duty-mode bit, and that bit decides how the latch is split into three or four slices. Each commit raises a single-cycle update pulse together with the group index. This pulse is a status strobe and not a stream, so no ready or back-pressure exists: a downstream consumer samples the latch in the cycle of the pulse, or in any later cycle before the next pulse.

Top module: `rx3w_frame_rx`

## Requirements
- R1: After reset the display latch and all setup outputs are 0, and no update pulse is seen until a valid frame completes.
- R2: The address is the last 8 bits sampled on serial-clock rising edges while chip enable is low, sent least significant bit first. The frame is committed only when those bits equal 40H. Any other value, for example the bit-reversed 02H, discards the frame with no pulse and no change to the latch or the setup register.
- R3: Exactly 104 data bits must be sampled while chip enable is high. A frame of 103 or 105 bits is discarded.
- R4: A commit happens on the falling edge of chip enable and raises `upd_valid` for exactly one system cycle. `upd_group` equals the group selector, formed from frame position 103 as bit 0 and position 104 as bit 1.
- R5: With the duty bit at 0 (three-slice mode), group g writes latch bits 87g to 87g+86. Frame position 1 goes to the lowest bit of the slice, and later positions go to rising bit indices. A group-3 frame in this mode is discarded.
- R6: With the duty bit at 1 (four-slice mode), groups 0 and 1 write 88 bits based at 0 and 88. Groups 2 and 3 write 84 bits based at 176 and 260.
- R7: Only a committed group-0 frame loads the setup register. Frame positions 94 through 102 map in that order to `port_sel[0..3]`, `bias_third`, `duty_quarter`, `frame_fast`, `seg_off` and `power_save`. Frames for other groups leave these outputs unchanged.
- R8: For a group-0 frame, the slice width is chosen from the duty bit carried inside that same frame, not from the stored duty bit.
- R9: Latch bits outside the addressed slice keep their values. Filler bits between the display bits and the group selector have no effect.
- R10: Frames are received identically whether the serial clock idles low or idles high between transfers.
- R11: The address must be resent for every frame. After a falling edge of chip enable, a data phase with no address bits before it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable from host (asynchronous) |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdi_i | input | 1 | Serial data from host (asynchronous) |
| disp_bits | output | 344 | Display latch contents |
| port_sel | output | 4 | Setup: segment/port selection bits |
| bias_third | output | 1 | Setup: bias selection bit |
| duty_quarter | output | 1 | Setup: 1 selects four-slice mode |
| frame_fast | output | 1 | Setup: frame-rate selection bit |
| seg_off | output | 1 | Setup: segments-off bit |
| power_save | output | 1 | Setup: power-saving bit |
| upd_valid | output | 1 | One-cycle commit pulse |
| upd_group | output | 2 | Group index of the last commit |

## Verification
The bench builds the block with its default parameters. These are an 8-bit address of 40H, a 104-bit frame, slice widths of 87, 88 and 84, and two synchroniser stages. With these values both latch splits can be checked against their exact bit boundaries, including the 261-bit limit in three-slice mode and the 344-bit full latch. The same values also cover the duty switch carried by a group-0 frame, a group-3 frame that is illegal in one mode and legal in the other, and frames that are one bit short or one bit long. Each of these stimuli is sent with the serial clock idling low and again with it idling high.

// File: rtl/rx3w_pkg.sv
package rx3w_pkg;
  // Setup register; declared MSB first, port_sel[0] is bit 0.
  typedef struct packed {
    logic       power_save;
    logic       seg_off;
    logic       frame_fast;
    logic       duty_quarter;
    logic       bias_third;
    logic [3:0] port_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int DD_W   = 2;
endpackage

// File: rtl/rx3w_sync.sv
module rx3w_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] pipe;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '0;
        prev <= 1'b0;
      end else begin
        pipe <= {pipe[STAGES-2:0], din[g]};
        prev <= pipe[STAGES-1];
      end
    end
    assign level[g] = pipe[STAGES-1];
    assign rise[g]  = pipe[STAGES-1] & ~prev;
    assign fall[g]  = ~pipe[STAGES-1] & prev;
  end
endmodule

// File: rtl/rx3w_shift.sv
module rx3w_shift #(
  parameter int ADDR_W  = 8,
  parameter int FRAME_W = 104,
  localparam int ACNT_W = $clog2(ADDR_W + 1),
  localparam int FCNT_W = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_lvl,
  input  logic               ce_fall,
  input  logic               sclk_rise,
  input  logic               sdi_lvl,
  output logic [ADDR_W-1:0]  addr_sr,
  output logic               addr_full,
  output logic [FRAME_W-1:0] frame_sr,
  output logic [FCNT_W-1:0]  frame_cnt
);
  logic [ACNT_W-1:0] acnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt      <= '0;
      addr_sr   <= '0;
      frame_sr  <= '0;
      frame_cnt <= '0;
    end else if (ce_fall) begin
      acnt      <= '0;
      frame_cnt <= '0;
    end else if (sclk_rise) begin
      if (ce_lvl) begin
        frame_sr <= {frame_sr[FRAME_W-2:0], sdi_lvl};
        if (frame_cnt != FCNT_W'(FRAME_W + 1)) frame_cnt <= frame_cnt + 1'b1;
      end else begin
        addr_sr <= {sdi_lvl, addr_sr[ADDR_W-1:1]};
        if (acnt != ACNT_W'(ADDR_W)) acnt <= acnt + 1'b1;
      end
    end
  end

  assign addr_full = (acnt == ACNT_W'(ADDR_W));

  // R11: end of a transfer forgets the address and the bit count
  a_r11_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> (frame_cnt == '0 && !addr_full));
endmodule

// File: rtl/rx3w_commit.sv
module rx3w_commit
  import rx3w_pkg::*;
#(
  parameter logic [7:0] ADDR    = 8'h40,
  parameter int ADDR_W          = 8,
  parameter int FRAME_W         = 104,
  parameter int W3              = 87,
  parameter int W4A             = 88,
  parameter int W4B             = 84,
  localparam int LATCH_W        = 2 * W4A + 2 * W4B,
  localparam int FCNT_W         = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_fall,
  input  logic [ADDR_W-1:0]  addr_sr,
  input  logic               addr_full,
  input  logic [FRAME_W-1:0] frame_sr,
  input  logic [FCNT_W-1:0]  frame_cnt,
  output logic [LATCH_W-1:0] disp_q,
  output ctrl_t              ctrl_q,
  output logic               upd_valid,
  output logic [1:0]         upd_group
);
  logic [1:0]         dd;
  logic [CTRL_W-1:0]  cvec;
  ctrl_t              ctrl_new;
  logic               duty_eff, legal, accept;
  int                 base, width;
  logic [LATCH_W-1:0] disp_nx;

  // frame position p sits at frame_sr[FRAME_W-p]
  assign dd = {frame_sr[0], frame_sr[1]};

  always_comb begin
    for (int k = 0; k < CTRL_W; k++) cvec[k] = frame_sr[DD_W + CTRL_W - 1 - k];
  end
  assign ctrl_new = ctrl_t'(cvec);

  assign duty_eff = (dd == 2'd0) ? ctrl_new.duty_quarter : ctrl_q.duty_quarter;
  assign legal    = duty_eff || (dd != 2'd3);
  assign accept   = ce_fall && addr_full && (addr_sr == ADDR[ADDR_W-1:0])
                    && (frame_cnt == FCNT_W'(FRAME_W)) && legal;

  always_comb begin
    if (duty_eff) begin
      if (dd < 2'd2) begin
        base  = W4A * int'(dd);
        width = W4A;
      end else begin
        base  = 2 * W4A + W4B * (int'(dd) - 2);
        width = W4B;
      end
    end else begin
      base  = W3 * int'(dd);
      width = W3;
    end
    disp_nx = disp_q;
    for (int i = 0; i < LATCH_W; i++) begin
      if (i >= base && i < base + width) disp_nx[i] = frame_sr[FRAME_W - 1 - (i - base)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q    <= '0;
      ctrl_q    <= '0;
      upd_valid <= 1'b0;
      upd_group <= 2'd0;
    end else begin
      upd_valid <= accept;
      if (accept) begin
        disp_q    <= disp_nx;
        upd_group <= dd;
        if (dd == 2'd0) ctrl_q <= ctrl_new;
      end
    end
  end

  // R4: the commit pulse never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);
  // R9: the latch only moves together with a commit pulse
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> $stable(disp_q));
  // R7: setup register only moves with a group-0 commit
  a_r7_ctrl_group0: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_group == 2'd0) |-> $stable(ctrl_q));
  // R5: group 3 never commits in three-slice mode
  a_r5_no_group3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !ctrl_q.duty_quarter) |-> (upd_group != 2'd3));
endmodule

// File: rtl/rx3w_frame_rx.sv
module rx3w_frame_rx
  import rx3w_pkg::*;
#(
  parameter logic [7:0] ADDR = 8'h40,
  parameter int ADDR_W       = 8,
  parameter int FRAME_W      = 104,
  parameter int W3           = 87,
  parameter int W4A          = 88,
  parameter int W4B          = 84,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic [2*W4A+2*W4B-1:0]     disp_bits,
  output logic [3:0]                 port_sel,
  output logic                       bias_third,
  output logic                       duty_quarter,
  output logic                       frame_fast,
  output logic                       seg_off,
  output logic                       power_save,
  output logic                       upd_valid,
  output logic [1:0]                 upd_group
);
  localparam int FCNT_W = $clog2(FRAME_W + 2);

  logic [2:0] lvl, rise, fall;
  logic [ADDR_W-1:0]  addr_sr;
  logic               addr_full;
  logic [FRAME_W-1:0] frame_sr;
  logic [FCNT_W-1:0]  frame_cnt;
  ctrl_t              ctrl_q;

  rx3w_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi_i, sclk_i, ce_i}),
    .level(lvl), .rise(rise), .fall(fall));

  rx3w_shift #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ce_lvl(lvl[0]), .ce_fall(fall[0]),
    .sclk_rise(rise[1]), .sdi_lvl(lvl[2]), .addr_sr(addr_sr),
    .addr_full(addr_full), .frame_sr(frame_sr), .frame_cnt(frame_cnt));

  rx3w_commit #(.ADDR(ADDR), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W),
                .W3(W3), .W4A(W4A), .W4B(W4B)) u_commit (
    .clk(clk), .rst_n(rst_n), .ce_fall(fall[0]), .addr_sr(addr_sr),
    .addr_full(addr_full), .frame_sr(frame_sr), .frame_cnt(frame_cnt),
    .disp_q(disp_bits), .ctrl_q(ctrl_q), .upd_valid(upd_valid),
    .upd_group(upd_group));

  assign port_sel     = ctrl_q.port_sel;
  assign bias_third   = ctrl_q.bias_third;
  assign duty_quarter = ctrl_q.duty_quarter;
  assign frame_fast   = ctrl_q.frame_fast;
  assign seg_off      = ctrl_q.seg_off;
  assign power_save   = ctrl_q.power_save;
endmodule

// File: tb/rx3w_frame_rx_bench.sv
module rx3w_frame_rx_bench;
  localparam int H  = 20;
  localparam int NV = 14;
  // {idle_hi, len(0 exact,1 short,2 long), addr[8], group[2], duty, seed[8]}
  localparam logic [21:0] VECS [0:NV-1] = '{
    {1'b0, 2'd0, 8'h40, 2'd0, 1'b0, 8'h5B},
    {1'b0, 2'd0, 8'h40, 2'd1, 1'b1, 8'h16},
    {1'b1, 2'd0, 8'h40, 2'd2, 1'b0, 8'h21},
    {1'b0, 2'd0, 8'h40, 2'd3, 1'b0, 8'h2C},
    {1'b0, 2'd0, 8'h41, 2'd1, 1'b0, 8'h37},
    {1'b1, 2'd1, 8'h40, 2'd1, 1'b0, 8'h42},
    {1'b0, 2'd2, 8'h40, 2'd2, 1'b0, 8'h4D},
    {1'b0, 2'd0, 8'h40, 2'd0, 1'b1, 8'hA7},
    {1'b1, 2'd0, 8'h40, 2'd1, 1'b0, 8'h63},
    {1'b0, 2'd0, 8'h40, 2'd2, 1'b0, 8'h6E},
    {1'b1, 2'd0, 8'h40, 2'd3, 1'b0, 8'h79},
    {1'b0, 2'd0, 8'h02, 2'd2, 1'b0, 8'h84},
    {1'b1, 2'd0, 8'h40, 2'd0, 1'b0, 8'hF2},
    {1'b0, 2'd0, 8'h40, 2'd1, 1'b0, 8'h9A}
  };

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [343:0] disp_bits;
  logic [3:0] port_sel;
  logic bias_third, duty_quarter, frame_fast, seg_off, power_save, upd_valid;
  logic [1:0] upd_group;

  rx3w_frame_rx u_rx3w_frame_rx (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .disp_bits(disp_bits), .port_sel(port_sel), .bias_third(bias_third),
    .duty_quarter(duty_quarter), .frame_fast(frame_fast), .seg_off(seg_off),
    .power_save(power_save), .upd_valid(upd_valid), .upd_group(upd_group));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, strobes = 0;
  logic [1:0] last_grp = 2'd0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n && upd_valid) begin
    strobes++;
    last_grp = upd_group;
  end

  task automatic chk(input bit ok, input string tag, input logic [343:0] act, input logic [343:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b, input bit idle_hi);
    sclk = 1'b0; sdi = b; #H;
    sclk = 1'b1; #H;
    if (!idle_hi) sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] addr, input bit with_addr, input int nbits,
                            input bit idle_hi, input logic [103:0] fb);
    ce = 1'b0; sclk = idle_hi; #(2*H);
    if (with_addr) for (int i = 0; i < 8; i++) bit_out(addr[i], idle_hi);
    #H; ce = 1'b1; #H;
    for (int p = 1; p <= nbits; p++) bit_out((p <= 104) ? fb[p-1] : 1'b0, idle_hi);
    #H; ce = 1'b0; #(4*H);
    repeat (20) @(negedge clk);
  endtask

  function automatic logic [8:0] ctrl_now();
    return {power_save, seg_off, frame_fast, duty_quarter, bias_third, port_sel};
  endfunction

  logic [343:0] m_disp;
  logic [8:0]   m_ctrl, c9;
  logic [103:0] fb;
  logic [21:0]  w;
  logic [1:0]   grp;
  logic [7:0]   seed, addr;
  logic         dty, deff, idle, exp_ok;
  int           base, width, nb, s0;
  string        tag;

  initial begin : wd
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_disp = '0; m_ctrl = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(disp_bits == '0, "R1 latch", disp_bits, '0);
    chk(ctrl_now() == '0, "R1 setup", 344'(ctrl_now()), '0);
    chk(strobes == 0, "R1 pulse", 344'(strobes), '0);

    for (int v = 0; v < NV; v++) begin
      w = VECS[v];
      idle = w[21]; addr = w[18:11]; grp = w[10:9]; dty = w[8]; seed = w[7:0];
      nb = (w[20:19] == 2'd0) ? 104 : (w[20:19] == 2'd1) ? 103 : 105;
      deff = (grp == 2'd0) ? dty : m_ctrl[5];
      if (deff) begin
        width = (grp < 2) ? 88 : 84;
        base  = (grp < 2) ? 88 * int'(grp) : 176 + 84 * (int'(grp) - 2);
      end else begin
        width = 87; base = 87 * int'(grp);
      end
      c9 = {seed[3], seed[2], seed[1], dty, seed[0], seed[7:4]};
      for (int p = 1; p <= 104; p++) begin
        if (p <= width) fb[p-1] = (((p * 37 + int'(seed) * 11) % 5) < 2);
        else if (p == 103) fb[p-1] = grp[0];
        else if (p == 104) fb[p-1] = grp[1];
        else if (grp == 2'd0 && p >= 94) fb[p-1] = c9[p-94];
        else fb[p-1] = 1'b1; // R9 filler bits set to 1
      end
      exp_ok = (addr == 8'h40) && (nb == 104) && (deff || grp != 2'd3);
      if (addr != 8'h40) tag = "R2";
      else if (nb != 104) tag = "R3";
      else if (!deff) tag = "R5";
      else tag = "R6";
      if (grp == 2'd0) tag = {tag, "/R8"};
      if (idle) tag = {tag, "/R10"};
      s0 = strobes;
      send_frame(addr, 1'b1, nb, idle, fb);
      if (exp_ok) begin
        for (int j = 0; j < width; j++) m_disp[base + j] = fb[j];
        if (grp == 2'd0) m_ctrl = c9;
      end
      chk((strobes - s0) == (exp_ok ? 1 : 0), {tag, "/R4 pulse count"},
          344'(strobes - s0), 344'(exp_ok ? 1 : 0));
      if (exp_ok) chk(last_grp == grp, {tag, "/R4 group"}, 344'(last_grp), 344'(grp));
      chk(disp_bits == m_disp, {tag, "/R9 latch"}, disp_bits, m_disp);
      chk(ctrl_now() == m_ctrl, {tag, "/R7 setup"}, 344'(ctrl_now()), 344'(m_ctrl));
    end

    // R11: data phase without a fresh address is discarded
    for (int p = 1; p <= 104; p++) fb[p-1] = (p <= 87) ? 1'b1 : (p == 103);
    s0 = strobes;
    send_frame(8'h40, 1'b0, 104, 1'b0, fb);
    chk(strobes == s0, "R11 pulse", 344'(strobes - s0), '0);
    chk(disp_bits == m_disp, "R11 latch", disp_bits, m_disp);

    // R5 upper boundary: bits above 260 untouched in three-slice mode
    chk(disp_bits[343:261] == m_disp[343:261], "R5 upper bits",
        344'(disp_bits[343:261]), 344'(m_disp[343:261]));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule